// File: doc/BRIEF.md
# Mirrored Storage Update Sequencer

This block orders the writes that keep one critical multi-word value safe in two storage areas: a main copy and a mirror copy. Two status bits, stored in the same medium as the data, record how far an update has got. Each update moves the status bits through a four-state cycle in which only one bit changes per step. The main copy is written while only the main bit is set. The mirror copy is written while only the mirror bit is set. This means that an interruption at any point leaves a status value that shows exactly which copy cannot be trusted.

All storage traffic goes through one generic command port. The sequencer presents a command (`cmd_valid`, `cmd_op`, `cmd_status`) and holds it until the storage side returns a one-cycle `cmd_ack`. A status read returns the stored bits on `rd_status` in the same cycle as its acknowledge. After reset, and whenever a check is requested while idle, the sequencer reads the status bits. It then carries out the copy that restores consistency, clears the bits and reports the copy direction on `rec_dir` with a `recovered` pulse.

Top module: `mirror_update_seq`

## Requirements
- R1: While `rst_n` is low, `busy` is 1. The internal reset is released on the second rising clock edge after `rst_n` rises. The first command issued is then a status read (`cmd_op` = 1).
- R2: An accepted update issues these commands in this order. Status write (`cmd_op` = 0) of 01. Main write from new data (`cmd_op` = 2). Status write of 11. Status write of 10. Mirror write from main (`cmd_op` = 3). Status write of 00. Status bit 0 is the main bit and bit 1 is the mirror bit.
- R3: Every status write differs in exactly one bit from the status value last written or read.
- R4: A command stays valid and unchanged until it is acknowledged. Each acknowledge advances the sequence by exactly one command.
- R5: `busy` is 0 only in the idle, both-clear state. `upd_req` and `chk_req` pulses that arrive while `busy` is 1 have no effect: no extra command and no extra completion pulse follow.
- R6: A status read that returns 00 is followed by no write. The sequencer returns to idle and reports `rec_dir` = 0 (no copy).
- R7: A status read that returns 01 is followed by a main write from the mirror (`cmd_op` = 4) and then a status write of 00. `rec_dir` = 1 (main restored).
- R8: A status read that returns 11 is followed by a status write of 10, a mirror write from main, and then a status write of 00. `rec_dir` = 2 (mirror restored). This holds as well after a reset that cuts an update short.
- R9: A status read that returns 10 is followed by a mirror write from main and then a status write of 00. `rec_dir` = 2.
- R10: `chk_req` in idle starts a status read. When `chk_req` and `upd_req` arrive in the same idle cycle, only the check is performed.
- R11: `upd_done` (after an update) or `recovered` (after a check) is high for exactly one cycle. It is the cycle after the final acknowledge, and `rec_dir` is valid while `recovered` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req | input | 1 | Request to store a new value (taken only in idle) |
| chk_req | input | 1 | Request to verify and repair the copies (taken only in idle) |
| busy | output | 1 | Sequence in progress; requests are not taken |
| upd_done | output | 1 | One-cycle pulse at the end of an update |
| recovered | output | 1 | One-cycle pulse at the end of a check |
| rec_dir | output | 2 | Copy performed by the last check: 0 none, 1 main restored, 2 mirror restored |
| cmd_valid | output | 1 | Storage command present |
| cmd_op | output | 3 | 0 status write, 1 status read, 2 main from new data, 3 mirror from main, 4 main from mirror |
| cmd_status | output | 2 | Status value for a status write (bit 0 main, bit 1 mirror) |
| cmd_ack | input | 1 | Storage acknowledge, one cycle per command |
| rd_status | input | 2 | Stored status bits, valid with the acknowledge of a status read |

## Verification
The bench drives every one of the four stored status values into a check, both from reset and from an idle request. A design that mixed up the repair direction would copy stale data over the only good copy. One run resets the block once the bench storage holds 11 in the middle of an update. This shows that the interrupted state is repaired towards the mirror, where a design that wrote two bits at once could leave an ambiguous value. Requests during a busy sequence, and a check and an update that arrive in the same cycle, are aimed at a design that would start a second sequence or let the update win. Acknowledges with added latency catch a design that advances or changes a command before its acknowledge.

// File: rtl/mus_pkg.sv
`timescale 1ns/1ps
package mus_pkg;
  localparam int ST_W  = 2;
  localparam int OP_W  = 3;
  localparam int DIR_W = 2;

  typedef logic [ST_W-1:0] st_t;

  // status bit 0 tracks the main copy, bit 1 tracks the mirror copy
  localparam st_t ST_CLEAN = 2'b00;
  localparam st_t ST_MAIN  = 2'b01;
  localparam st_t ST_BOTH  = 2'b11;
  localparam st_t ST_MIRR  = 2'b10;

  typedef enum logic [OP_W-1:0] {
    OP_ST_WR         = 3'd0,
    OP_ST_RD         = 3'd1,
    OP_MAIN_NEW      = 3'd2,
    OP_MIRR_FROM_MN  = 3'd3,
    OP_MAIN_FROM_MR  = 3'd4
  } op_e;

  typedef enum logic [DIR_W-1:0] {
    DIR_NONE = 2'd0,
    DIR_MAIN = 2'd1,
    DIR_MIRR = 2'd2
  } dir_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_READ,
    S_SET_MAIN,
    S_WR_MAIN,
    S_SET_BOTH,
    S_DROP_MAIN,
    S_WR_MIRR,
    S_CLEAR,
    S_FIX_MAIN
  } state_e;
endpackage

// File: rtl/mus_rst_sync.sv
`timescale 1ns/1ps
module mus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/mus_cmd_drive.sv
`timescale 1ns/1ps
module mus_cmd_drive
  import mus_pkg::*;
(
  input  state_e state,
  output logic   cmd_valid,
  output op_e    cmd_op,
  output st_t    cmd_status
);
  always_comb begin
    cmd_valid  = 1'b1;
    cmd_op     = OP_ST_WR;
    cmd_status = ST_CLEAN;
    unique case (state)
      S_IDLE:      cmd_valid = 1'b0;
      S_READ:      cmd_op = OP_ST_RD;
      S_SET_MAIN:  cmd_status = ST_MAIN;
      S_WR_MAIN:   cmd_op = OP_MAIN_NEW;
      S_SET_BOTH:  cmd_status = ST_BOTH;
      S_DROP_MAIN: cmd_status = ST_MIRR;
      S_WR_MIRR:   cmd_op = OP_MIRR_FROM_MN;
      S_CLEAR:     cmd_status = ST_CLEAN;
      S_FIX_MAIN:  cmd_op = OP_MAIN_FROM_MR;
      default:     cmd_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/mus_recover_decode.sv
`timescale 1ns/1ps
module mus_recover_decode
  import mus_pkg::*;
(
  input  st_t    rd_status,
  output state_e dec_nxt,
  output dir_e   dec_dir
);
  always_comb begin
    unique case (rd_status)
      ST_MAIN: begin dec_nxt = S_FIX_MAIN;  dec_dir = DIR_MAIN; end
      ST_BOTH: begin dec_nxt = S_DROP_MAIN; dec_dir = DIR_MIRR; end
      ST_MIRR: begin dec_nxt = S_WR_MIRR;   dec_dir = DIR_MIRR; end
      default: begin dec_nxt = S_IDLE;      dec_dir = DIR_NONE; end
    endcase
  end
endmodule

// File: rtl/mus_seq_fsm.sv
`timescale 1ns/1ps
module mus_seq_fsm
  import mus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd_req,
  input  logic   chk_req,
  input  logic   cmd_ack,
  input  st_t    rd_status,
  input  logic   cmd_valid,
  input  op_e    cmd_op,
  input  st_t    cmd_status,
  input  state_e dec_nxt,
  input  dir_e   dec_dir,
  output state_e state,
  output logic   busy,
  output logic   upd_done,
  output logic   recovered,
  output dir_e   rec_dir
);
  state_e state_nx;
  logic   in_rec_q, in_rec_nx, in_rec_en;
  dir_e   dir_nx;
  logic   dir_en;
  st_t    shadow_q, shadow_nx;
  logic   shadow_en;
  logic   done_nx, rec_nx;
  logic   hs;

  assign hs   = cmd_valid && cmd_ack;
  assign busy = (state != S_IDLE);

  always_comb begin
    state_nx  = state;
    in_rec_nx = in_rec_q;
    in_rec_en = 1'b0;
    dir_nx    = rec_dir;
    dir_en    = 1'b0;
    done_nx   = 1'b0;
    rec_nx    = 1'b0;
    shadow_en = hs && ((cmd_op == OP_ST_RD) || (cmd_op == OP_ST_WR));
    shadow_nx = (cmd_op == OP_ST_RD) ? rd_status : cmd_status;
    unique case (state)
      S_IDLE: begin
        if (chk_req) begin
          state_nx = S_READ;     in_rec_nx = 1'b1; in_rec_en = 1'b1;
        end else if (upd_req) begin
          state_nx = S_SET_MAIN; in_rec_nx = 1'b0; in_rec_en = 1'b1;
        end
      end
      S_READ: if (hs) begin
        state_nx = dec_nxt;
        dir_nx   = dec_dir;
        dir_en   = 1'b1;
        rec_nx   = (dec_nxt == S_IDLE);
      end
      S_SET_MAIN:  if (hs) state_nx = S_WR_MAIN;
      S_WR_MAIN:   if (hs) state_nx = S_SET_BOTH;
      S_SET_BOTH:  if (hs) state_nx = S_DROP_MAIN;
      S_DROP_MAIN: if (hs) state_nx = S_WR_MIRR;
      S_WR_MIRR:   if (hs) state_nx = S_CLEAR;
      S_FIX_MAIN:  if (hs) state_nx = S_CLEAR;
      S_CLEAR: if (hs) begin
        state_nx = S_IDLE;
        rec_nx   = in_rec_q;
        done_nx  = !in_rec_q;
      end
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_READ;
      in_rec_q  <= 1'b1;
      rec_dir   <= DIR_NONE;
      shadow_q  <= ST_CLEAN;
      upd_done  <= 1'b0;
      recovered <= 1'b0;
    end else begin
      state     <= state_nx;
      upd_done  <= done_nx;
      recovered <= rec_nx;
      if (in_rec_en) in_rec_q <= in_rec_nx;
      if (dir_en)    rec_dir  <= dir_nx;
      if (shadow_en) shadow_q <= shadow_nx;
    end
  end

  // R3: one status bit per step relative to the last known stored value
  p_one_bit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ST_WR) |-> ($countones(cmd_status ^ shadow_q) == 1));

  // R4: a command is held until acknowledged
  p_hold_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_status)));

  // R2: main copy is written only while the main bit alone is stored
  p_main_marked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MAIN_NEW) |-> (shadow_q == ST_MAIN));

  // R8: mirror copy is written only while the mirror bit alone is stored
  p_mirr_marked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_MIRR_FROM_MN) |-> (shadow_q == ST_MIRR));

  // R5: no storage traffic while idle
  p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  // R11: completion flags are single-cycle and never together
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);
  p_rec_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    recovered |=> !recovered);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_done && recovered));
endmodule

// File: rtl/mirror_update_seq.sv
`timescale 1ns/1ps
module mirror_update_seq
  import mus_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd_req,
  input  logic                   chk_req,
  output logic                   busy,
  output logic                   upd_done,
  output logic                   recovered,
  output logic [DIR_W-1:0]       rec_dir,
  output logic                   cmd_valid,
  output logic [OP_W-1:0]        cmd_op,
  output logic [ST_W-1:0]        cmd_status,
  input  logic                   cmd_ack,
  input  logic [ST_W-1:0]        rd_status
);
  logic   rst_sync_n;
  state_e state;
  op_e    op_w;
  st_t    status_w;
  logic   valid_w;
  state_e dec_nxt;
  dir_e   dec_dir;
  dir_e   dir_w;

  mus_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  mus_cmd_drive u_drive (
    .state(state), .cmd_valid(valid_w), .cmd_op(op_w), .cmd_status(status_w)
  );

  mus_recover_decode u_dec (
    .rd_status(rd_status), .dec_nxt(dec_nxt), .dec_dir(dec_dir)
  );

  mus_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .upd_req(upd_req), .chk_req(chk_req),
    .cmd_ack(cmd_ack), .rd_status(rd_status), .cmd_valid(valid_w),
    .cmd_op(op_w), .cmd_status(status_w), .dec_nxt(dec_nxt), .dec_dir(dec_dir),
    .state(state), .busy(busy), .upd_done(upd_done), .recovered(recovered),
    .rec_dir(dir_w)
  );

  assign cmd_valid  = valid_w;
  assign cmd_op     = op_w;
  assign cmd_status = status_w;
  assign rec_dir    = dir_w;
endmodule

// File: tb/mirror_update_seq_bench.sv
`timescale 1ns/1ps
module mirror_update_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_req = 1'b0, chk_req = 1'b0;
  logic       busy, upd_done, recovered;
  logic [1:0] rec_dir;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [1:0] cmd_status;
  logic       cmd_ack = 1'b0;
  logic [1:0] rd_status = 2'b00;

  int compared = 0, mismatched = 0;
  int exp_q[$];
  logic [1:0] mem_st = 2'b00;   // bench storage of the status bits
  int lat = 0, wcnt = 0;
  bit resp_en = 1'b0;
  int done_cnt = 0, rec_cnt = 0, last_dir = -1;
  bit prev_done = 1'b0, prev_rec = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mirror_update_seq u_mirror_update_seq (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .chk_req(chk_req),
    .busy(busy), .upd_done(upd_done), .recovered(recovered), .rec_dir(rec_dir),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_status(cmd_status),
    .cmd_ack(cmd_ack), .rd_status(rd_status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic expect_cmd(input int op, input int st);
    exp_q.push_back(op * 4 + st);
  endtask

  // storage responder and per-clock reference comparison
  always @(negedge clk) begin
    if (!rst_n || !resp_en) begin
      cmd_ack = 1'b0;
      wcnt = 0;
    end else if (cmd_ack) begin
      cmd_ack = 1'b0;
    end else if (cmd_valid) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected command op", int'(cmd_op), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(cmd_op) == e / 4, cur_req, "command op", int'(cmd_op), e / 4);
          if (cmd_op == 3'd0)
            check(int'(cmd_status) == e % 4, "R3", "status write value",
                  int'(cmd_status), e % 4);
        end
        if (cmd_op == 3'd1) rd_status = mem_st;
        if (cmd_op == 3'd0) mem_st = cmd_status;
        cmd_ack = 1'b1;
      end else begin
        wcnt++;
      end
    end
    if (rst_n) begin
      check(!( !busy && cmd_valid), "R5", "command while idle", int'(cmd_valid), 0);
      check(!(upd_done && prev_done), "R11", "upd_done width", 2, 1);
      check(!(recovered && prev_rec), "R11", "recovered width", 2, 1);
    end
    if (upd_done) done_cnt++;
    if (recovered) begin rec_cnt++; last_dir = int'(rec_dir); end
    prev_done = upd_done;
    prev_rec  = recovered;
  end

  task automatic do_reset();
    @(negedge clk);
    resp_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R1", "busy during reset", int'(busy), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);   // internal release after two edges
    resp_en = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input bit u, input bit c);
    @(negedge clk);
    upd_req = u; chk_req = c;
    @(negedge clk);
    upd_req = 1'b0; chk_req = 1'b0;
  endtask

  task automatic expect_update();
    expect_cmd(0, 1); expect_cmd(2, 0); expect_cmd(0, 3);
    expect_cmd(0, 2); expect_cmd(3, 0); expect_cmd(0, 0);
  endtask

  initial begin
    int d0, r0;
    // R1 / R6: power-up with clean status
    cur_req = "R6"; mem_st = 2'b00; lat = 0;
    expect_cmd(1, 0);
    do_reset();
    wait_idle();
    check(exp_q.size() == 0, "R1", "power-up read issued", exp_q.size(), 0);
    check(rec_cnt == 1, "R6", "recovered pulses", rec_cnt, 1);
    check(last_dir == 0, "R6", "direction none", last_dir, 0);

    // R2 / R4: update with slow acknowledge
    cur_req = "R2"; lat = 2; d0 = done_cnt;
    expect_update();
    pulse(1'b1, 1'b0);
    wait_idle();
    check(exp_q.size() == 0, "R2", "update commands left", exp_q.size(), 0);
    check(done_cnt == d0 + 1, "R11", "upd_done pulses", done_cnt - d0, 1);
    check(mem_st == 2'b00, "R2", "status after update", int'(mem_st), 0);

    // R5: requests while busy are ignored
    cur_req = "R5"; lat = 1; d0 = done_cnt; r0 = rec_cnt;
    expect_update();
    pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    wait_idle();
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5", "commands left", exp_q.size(), 0);
    check(done_cnt == d0 + 1, "R5", "upd_done pulses", done_cnt - d0, 1);
    check(rec_cnt == r0, "R5", "recovered pulses", rec_cnt - r0, 0);
    check(busy == 1'b0, "R5", "busy after ignored requests", int'(busy), 0);

    // R10 / R7: check request, main corrupt
    cur_req = "R7"; lat = 0; mem_st = 2'b01; r0 = rec_cnt;
    expect_cmd(1, 0); expect_cmd(4, 0); expect_cmd(0, 0);
    pulse(1'b0, 1'b1);
    wait_idle();
    check(exp_q.size() == 0, "R10", "check commands left", exp_q.size(), 0);
    check(rec_cnt == r0 + 1, "R7", "recovered pulses", rec_cnt - r0, 1);
    check(last_dir == 1, "R7", "direction main", last_dir, 1);

    // R8: both bits set, via check request
    cur_req = "R8"; lat = 1; mem_st = 2'b11;
    expect_cmd(1, 0); expect_cmd(0, 2); expect_cmd(3, 0); expect_cmd(0, 0);
    pulse(1'b0, 1'b1);
    wait_idle();
    check(exp_q.size() == 0, "R8", "commands left", exp_q.size(), 0);
    check(last_dir == 2, "R8", "direction mirror", last_dir, 2);
    check(mem_st == 2'b00, "R8", "status after repair", int'(mem_st), 0);

    // R9: mirror bit only, found at power-up
    cur_req = "R9"; lat = 0; mem_st = 2'b10; r0 = rec_cnt;
    expect_cmd(1, 0); expect_cmd(3, 0); expect_cmd(0, 0);
    do_reset();
    wait_idle();
    check(exp_q.size() == 0, "R9", "commands left", exp_q.size(), 0);
    check(rec_cnt == r0 + 1, "R9", "recovered pulses", rec_cnt - r0, 1);
    check(last_dir == 2, "R9", "direction mirror", last_dir, 2);

    // R10: check wins over a simultaneous update
    cur_req = "R10"; lat = 0; d0 = done_cnt; r0 = rec_cnt;
    expect_cmd(1, 0);
    pulse(1'b1, 1'b1);
    wait_idle();
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R10", "commands left", exp_q.size(), 0);
    check(done_cnt == d0, "R10", "update not run", done_cnt - d0, 0);
    check(rec_cnt == r0 + 1, "R10", "check run", rec_cnt - r0, 1);

    // R8: update cut short by reset once both bits are stored
    cur_req = "R8"; lat = 1;
    expect_cmd(0, 1); expect_cmd(2, 0); expect_cmd(0, 3);
    pulse(1'b1, 1'b0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (mem_st == 2'b11) break;
    end
    check(exp_q.size() == 0, "R8", "commands before cut", exp_q.size(), 0);
    expect_cmd(1, 0); expect_cmd(0, 2); expect_cmd(3, 0); expect_cmd(0, 0);
    do_reset();
    wait_idle();
    check(exp_q.size() == 0, "R8", "repair commands left", exp_q.size(), 0);
    check(last_dir == 2, "R8", "direction after cut", last_dir, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule